// File: doc/BRIEF.md
# Serial Interface Status Flag Register

This block keeps the eight event flags of a serial interface that runs either as a two-wire I2C-style bus engine or as a clock-synchronous shifter. The shifter, the clock generator and the address comparator sit outside the block. They report what happened as one-cycle event strobes. The block turns each strobe into a sticky flag under that flag's own rule, which can depend on the mode. It presents the flags as one registered status byte.

The CPU clears a flag with two accesses: it reads the status byte, then writes 0 to the bit it saw as 1. A flag can also clear as a side effect of touching a data register. Reading the receive-data register clears receive-full. Writing the transmit-data register clears the two transmit flags.

An interrupt request is formed from the flags and a per-flag enable vector that arrives as an input.

Top module: `ser_status_flags`

## Requirements
- R1: During and after a synchronous reset (`rst` high), `status` reads 8'h00 and `irq` reads 0.
- R2: Each flag becomes visible on `status` on the clock edge that samples its event strobe. The bit positions are: b7 tx-empty, b6 tx-done, b5 rx-full, b4 no-ack, b3 stop-seen, b2 arbitration-lost/overrun, b1 own-address-hit, b0 general-call.
- R3: A write to `st_wdata` with `st_wr` high clears a bit only if two things hold: the bit is 0 in the written byte, and the bit was 1 in the most recent `st_rd` read since the previous write. Every read reloads this per-bit memory and every write empties it. When a read and a write share a cycle, the write uses the memory from before that read. Writing 1 never clears a bit.
- R4: `ev_rx_load` sets b5. `rxd_rd` clears b5.
- R5: b7 is set by any of `ev_tx_load`, `ev_tx_mode_sel`, `ev_start_gen` or `ev_slave_rx2tx`. `txd_wr` clears both b7 and b6.
- R6: b6 sets differently by mode. With `sync_mode`=0 it sets on `ev_ninth_clk` while b7 is already 1. With `sync_mode`=1 it sets on `ev_last_tx_bit`.
- R7: b2 sets differently by mode. With `sync_mode`=0 it sets on `ev_sda_mismatch` while `is_master` and `is_tx` are both 1, or on `ev_start_sda_hi` while `is_master`=1. With `sync_mode`=1 it sets on `ev_last_rx_bit` while b5 is already 1 (overrun).
- R8: b4 sets on `ev_nack` only when `sync_mode`=0.
- R9: b1 sets on `ev_addr_match` only when `sync_mode`=0, `is_master`=0 and `is_tx`=0. b0 sets on `ev_gcall` only when `sync_mode`=0.
- R10: b3 sets on `ev_stop_det` with `sync_mode`=0 only if a frame has been completed. A frame counts as completed when an `ev_ninth_clk` occurred in an earlier cycle, after the last `ev_start_det` and the last stop. `ev_start_det` cancels that memory, and so does a stop. A start in the same cycle as a ninth clock cancels it.
- R11: When a set event and any clear of the same bit fall in the same cycle, the bit ends up 1.
- R12: `irq` equals the OR of (`status` AND `irq_en`), computed from the same edge's flag values and the `irq_en` sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1 = clock-synchronous mode, 0 = I2C mode |
| is_master | input | 1 | Bus engine is master |
| is_tx | input | 1 | Bus engine is transmitting |
| ev_start_det | input | 1 | Start condition detected on the bus |
| ev_start_gen | input | 1 | Start or repeated start generated |
| ev_stop_det | input | 1 | Stop condition detected |
| ev_ninth_clk | input | 1 | Ninth SCL clock of a byte |
| ev_rx_load | input | 1 | Receive shifter moved into the receive-data register |
| ev_tx_load | input | 1 | Transmit-data register moved into the shifter |
| ev_tx_mode_sel | input | 1 | Transmit mode selected |
| ev_slave_rx2tx | input | 1 | Slave receive changed to slave transmit |
| ev_addr_match | input | 1 | First frame after start matched own address |
| ev_gcall | input | 1 | General call address detected |
| ev_sda_mismatch | input | 1 | Driven SDA differed from pin at SCL rise |
| ev_start_sda_hi | input | 1 | Start seen while SDA held high in master mode |
| ev_nack | input | 1 | Receiver returned no acknowledge |
| ev_last_tx_bit | input | 1 | Last bit of a synchronous frame shifted out |
| ev_last_rx_bit | input | 1 | Last bit of a synchronous frame received |
| st_rd | input | 1 | CPU read of the status byte |
| st_wr | input | 1 | CPU write of the status byte |
| st_wdata | input | 8 | Status write data |
| rxd_rd | input | 1 | CPU read of the receive-data register |
| txd_wr | input | 1 | CPU write of the transmit-data register |
| irq_en | input | 8 | Per-flag interrupt enables |
| status | output | 8 | Registered status byte |
| irq | output | 1 | Registered interrupt request |

## Verification
Every result is due on the edge that samples its strobe. Inputs are driven 1 ns after a rising edge, and a flag or `irq` caused by them is compared 1 ns after the next rising edge. The read-then-write clear takes two accesses, so it is checked over two such steps, and the status seen by the read is the value registered before that read. The conditional sets read the flags as they stand before the event edge, and the bench model uses those same pre-edge values. These sets are tx-done gated by tx-empty, overrun gated by rx-full, and stop gated by an earlier ninth clock.

// File: rtl/ser_status_pkg.sv
package ser_status_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned B_TXE    = 7;
  localparam int unsigned B_TXDONE = 6;
  localparam int unsigned B_RXF    = 5;
  localparam int unsigned B_NACK   = 4;
  localparam int unsigned B_STOP   = 3;
  localparam int unsigned B_ALOV   = 2;
  localparam int unsigned B_ADDR   = 1;
  localparam int unsigned B_GCALL  = 0;

  typedef logic [FLAG_W-1:0] flags_t;

  typedef struct packed {
    logic start_det;
    logic start_gen;
    logic stop_det;
    logic ninth_clk;
    logic rx_load;
    logic tx_load;
    logic tx_mode_sel;
    logic slave_rx2tx;
    logic addr_match;
    logic gcall;
    logic sda_mismatch;
    logic start_sda_hi;
    logic nack;
    logic last_tx;
    logic last_rx;
  } ev_t;
endpackage

// File: rtl/ser_status_setlogic.sv
module ser_status_setlogic
  import ser_status_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ev_t    ev,
  input  logic   sync_mode,
  input  logic   is_master,
  input  logic   is_tx,
  input  flags_t cur,
  output flags_t set_vec
);
  logic frame_done;

  // Remembers that a byte finished since the last start or stop.
  always_ff @(posedge clk) begin
    if (rst)                   frame_done <= 1'b0;
    else if (ev.start_det)     frame_done <= 1'b0;
    else if (ev.ninth_clk)     frame_done <= 1'b1;
    else if (ev.stop_det)      frame_done <= 1'b0;
  end

  logic i2c;
  assign i2c = ~sync_mode;

  always_comb begin
    set_vec           = '0;
    set_vec[B_TXE]    = ev.tx_load | ev.tx_mode_sel | ev.start_gen | ev.slave_rx2tx;
    set_vec[B_TXDONE] = sync_mode ? ev.last_tx : (ev.ninth_clk & cur[B_TXE]);
    set_vec[B_RXF]    = ev.rx_load;
    set_vec[B_NACK]   = i2c & ev.nack;
    set_vec[B_STOP]   = i2c & ev.stop_det & frame_done;
    set_vec[B_ALOV]   = sync_mode ? (ev.last_rx & cur[B_RXF])
                                  : (is_master & ((is_tx & ev.sda_mismatch) | ev.start_sda_hi));
    set_vec[B_ADDR]   = i2c & ~is_master & ~is_tx & ev.addr_match;
    set_vec[B_GCALL]  = i2c & ev.gcall;
  end
endmodule

// File: rtl/ser_status_clrtrack.sv
module ser_status_clrtrack
  import ser_status_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   st_rd,
  input  logic   st_wr,
  input  flags_t st_wdata,
  input  flags_t cur,
  output flags_t sw_clr
);
  flags_t seen;

  // Per-bit memory of flags observed as 1 by the last status read.
  always_ff @(posedge clk) begin
    if (rst)        seen <= '0;
    else if (st_rd) seen <= cur;
    else if (st_wr) seen <= '0;
  end

  assign sw_clr = st_wr ? (seen & ~st_wdata) : '0;
endmodule

// File: rtl/ser_status_flags.sv
module ser_status_flags
  import ser_status_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sync_mode,
  input  logic        is_master,
  input  logic        is_tx,
  input  logic        ev_start_det,
  input  logic        ev_start_gen,
  input  logic        ev_stop_det,
  input  logic        ev_ninth_clk,
  input  logic        ev_rx_load,
  input  logic        ev_tx_load,
  input  logic        ev_tx_mode_sel,
  input  logic        ev_slave_rx2tx,
  input  logic        ev_addr_match,
  input  logic        ev_gcall,
  input  logic        ev_sda_mismatch,
  input  logic        ev_start_sda_hi,
  input  logic        ev_nack,
  input  logic        ev_last_tx_bit,
  input  logic        ev_last_rx_bit,
  input  logic        st_rd,
  input  logic        st_wr,
  input  logic [7:0]  st_wdata,
  input  logic        rxd_rd,
  input  logic        txd_wr,
  input  logic [7:0]  irq_en,
  output logic [7:0]  status,
  output logic        irq
);
  ev_t    ev;
  flags_t set_vec, sw_clr, side_clr, nxt;

  assign ev = '{start_det: ev_start_det, start_gen: ev_start_gen, stop_det: ev_stop_det,
                ninth_clk: ev_ninth_clk, rx_load: ev_rx_load, tx_load: ev_tx_load,
                tx_mode_sel: ev_tx_mode_sel, slave_rx2tx: ev_slave_rx2tx,
                addr_match: ev_addr_match, gcall: ev_gcall, sda_mismatch: ev_sda_mismatch,
                start_sda_hi: ev_start_sda_hi, nack: ev_nack, last_tx: ev_last_tx_bit,
                last_rx: ev_last_rx_bit};

  ser_status_setlogic u_set (
    .clk(clk), .rst(rst), .ev(ev), .sync_mode(sync_mode), .is_master(is_master),
    .is_tx(is_tx), .cur(status), .set_vec(set_vec)
  );

  ser_status_clrtrack u_clr (
    .clk(clk), .rst(rst), .st_rd(st_rd), .st_wr(st_wr), .st_wdata(st_wdata),
    .cur(status), .sw_clr(sw_clr)
  );

  always_comb begin
    side_clr           = '0;
    side_clr[B_RXF]    = rxd_rd;
    side_clr[B_TXE]    = txd_wr;
    side_clr[B_TXDONE] = txd_wr;
  end

  // Set events override any clear of the same bit.
  genvar gi;
  generate
    for (gi = 0; gi < FLAG_W; gi++) begin : g_bit
      assign nxt[gi] = set_vec[gi] | (status[gi] & ~(sw_clr[gi] | side_clr[gi]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= nxt;
      irq    <= |(nxt & irq_en);
    end
  end
endmodule

// File: rtl/ser_status_chk.sv
module ser_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_rx_load,
  input logic       ev_tx_load,
  input logic       ev_tx_mode_sel,
  input logic       ev_start_gen,
  input logic       ev_slave_rx2tx,
  input logic       ev_ninth_clk,
  input logic       ev_last_tx_bit,
  input logic       st_wr,
  input logic [7:0] st_wdata,
  input logic       rxd_rd,
  input logic       txd_wr,
  input logic [7:0] irq_en,
  input logic [7:0] status,
  input logic       irq
);
  // R4
  rx_load_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ev_rx_load |=> status[5]);

  // R4
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rxd_rd && !ev_rx_load) |=> !status[5]);

  // R5
  tx_load_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ev_tx_load |=> status[7]);

  // R5
  tx_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (txd_wr && !ev_tx_load && !ev_tx_mode_sel && !ev_start_gen && !ev_slave_rx2tx
     && !ev_ninth_clk && !ev_last_tx_bit) |=> (status[7:6] == 2'b00));

  // R3
  ones_never_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (st_wr && st_wdata == 8'hFF && !rxd_rd && !txd_wr) |=> (($past(status) & ~status) == 8'h00));

  // R3
  rxf_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status[5]) |-> ($past(rxd_rd) || $past(st_wr)));

  // R12
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |(status & $past(irq_en))));
endmodule

bind ser_status_flags ser_status_chk u_chk (
  .clk(clk), .rst(rst), .ev_rx_load(ev_rx_load), .ev_tx_load(ev_tx_load),
  .ev_tx_mode_sel(ev_tx_mode_sel), .ev_start_gen(ev_start_gen),
  .ev_slave_rx2tx(ev_slave_rx2tx), .ev_ninth_clk(ev_ninth_clk),
  .ev_last_tx_bit(ev_last_tx_bit), .st_wr(st_wr), .st_wdata(st_wdata),
  .rxd_rd(rxd_rd), .txd_wr(txd_wr), .irq_en(irq_en), .status(status), .irq(irq)
);

// File: tb/ser_status_flags_bench.sv
`timescale 1ns/1ps
module ser_status_flags_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, sync_mode, is_master, is_tx;
  logic ev_start_det, ev_start_gen, ev_stop_det, ev_ninth_clk, ev_rx_load, ev_tx_load;
  logic ev_tx_mode_sel, ev_slave_rx2tx, ev_addr_match, ev_gcall, ev_sda_mismatch;
  logic ev_start_sda_hi, ev_nack, ev_last_tx_bit, ev_last_rx_bit;
  logic st_rd, st_wr, rxd_rd, txd_wr;
  logic [7:0] st_wdata, irq_en, status;
  logic irq;

  ser_status_flags u_ser_status_flags (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m_st, m_seen;
  logic m_frame, m_irq;

  task automatic idle();
    {ev_start_det, ev_start_gen, ev_stop_det, ev_ninth_clk, ev_rx_load, ev_tx_load,
     ev_tx_mode_sel, ev_slave_rx2tx, ev_addr_match, ev_gcall, ev_sda_mismatch,
     ev_start_sda_hi, ev_nack, ev_last_tx_bit, ev_last_rx_bit} = '0;
    {st_rd, st_wr, rxd_rd, txd_wr} = '0;
    st_wdata = 8'hFF;
  endtask

  // Expected next state from the requirements.
  task automatic model_step();
    logic [7:0] s, c, nx;
    s = '0;
    s[7] = ev_tx_load | ev_tx_mode_sel | ev_start_gen | ev_slave_rx2tx;       // R5
    s[6] = sync_mode ? ev_last_tx_bit : (ev_ninth_clk & m_st[7]);            // R6
    s[5] = ev_rx_load;                                                       // R4
    s[4] = !sync_mode & ev_nack;                                             // R8
    s[3] = !sync_mode & ev_stop_det & m_frame;                               // R10
    s[2] = sync_mode ? (ev_last_rx_bit & m_st[5])
                     : (is_master & ((is_tx & ev_sda_mismatch) | ev_start_sda_hi)); // R7
    s[1] = !sync_mode & !is_master & !is_tx & ev_addr_match;                 // R9
    s[0] = !sync_mode & ev_gcall;
    c = st_wr ? (m_seen & ~st_wdata) : 8'h00;                                // R3
    if (rxd_rd) c[5] = 1'b1;
    if (txd_wr) c[7:6] = 2'b11;
    nx = (m_st & ~c) | s;                                                    // R11
    m_seen  = st_rd ? m_st : (st_wr ? 8'h00 : m_seen);
    m_frame = ev_start_det ? 1'b0 : (ev_ninth_clk ? 1'b1 : (ev_stop_det ? 1'b0 : m_frame));
    m_st  = nx;
    m_irq = |(nx & irq_en);                                                  // R12
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive-time model update, then compare 1 ns after the sampling edge.
  task automatic tick(string tag);
    model_step();
    @(posedge clk); #1;
    chk(tag, status, m_st);
    chk("R12", {7'd0, irq}, {7'd0, m_irq});
    idle();
  endtask

  task automatic rand_inputs();
    {ev_start_det, ev_start_gen, ev_stop_det, ev_ninth_clk, ev_rx_load, ev_tx_load,
     ev_tx_mode_sel, ev_slave_rx2tx, ev_addr_match, ev_gcall, ev_sda_mismatch,
     ev_start_sda_hi, ev_nack, ev_last_tx_bit, ev_last_rx_bit} = '0;
    if ($urandom % 7 == 0) ev_start_det    = 1; if ($urandom % 9 == 0) ev_start_gen   = 1;
    if ($urandom % 7 == 0) ev_stop_det     = 1; if ($urandom % 5 == 0) ev_ninth_clk   = 1;
    if ($urandom % 6 == 0) ev_rx_load      = 1; if ($urandom % 7 == 0) ev_tx_load     = 1;
    if ($urandom % 12 == 0) ev_tx_mode_sel = 1; if ($urandom % 12 == 0) ev_slave_rx2tx = 1;
    if ($urandom % 8 == 0) ev_addr_match   = 1; if ($urandom % 10 == 0) ev_gcall      = 1;
    if ($urandom % 9 == 0) ev_sda_mismatch = 1; if ($urandom % 11 == 0) ev_start_sda_hi = 1;
    if ($urandom % 8 == 0) ev_nack         = 1; if ($urandom % 6 == 0) ev_last_tx_bit = 1;
    if ($urandom % 6 == 0) ev_last_rx_bit  = 1;
    st_rd  = ($urandom % 3 == 0);
    st_wr  = ($urandom % 3 == 0);
    st_wdata = $urandom;
    rxd_rd = ($urandom % 5 == 0);
    txd_wr = ($urandom % 6 == 0);
    if ($urandom % 20 == 0) irq_en = $urandom;
    if ($urandom % 25 == 0) sync_mode = ~sync_mode;
    is_master = $urandom; is_tx = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle();
    sync_mode = 0; is_master = 0; is_tx = 0; irq_en = 8'hFF;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", status, 8'h00);
    chk("R1", {7'd0, irq}, 8'h00);
    rst = 0;
    m_st = 0; m_seen = 0; m_frame = 0; m_irq = 0;

    // R3: write 0 with no prior read keeps the flag; read then write 0 clears it.
    ev_rx_load = 1; tick("R4");
    chk("R4", status & 8'h20, 8'h20);
    st_wr = 1; st_wdata = 8'h00; tick("R3");
    chk("R3", status & 8'h20, 8'h20);
    st_rd = 1; tick("R3");
    st_wr = 1; st_wdata = 8'hFF; tick("R3");
    chk("R3", status & 8'h20, 8'h20);
    st_rd = 1; tick("R3");
    st_wr = 1; st_wdata = 8'hDF; tick("R3");
    chk("R3", status & 8'h20, 8'h00);

    // R11: set and software clear in one cycle, set wins.
    ev_rx_load = 1; tick("R4");
    st_rd = 1; tick("R3");
    st_wr = 1; st_wdata = 8'h00; ev_rx_load = 1; tick("R11");
    chk("R11", status & 8'h20, 8'h20);
    rxd_rd = 1; tick("R4");
    chk("R4", status & 8'h20, 8'h00);

    // R10: stop needs a completed frame.
    ev_start_det = 1; tick("R10");
    ev_stop_det = 1; tick("R10");
    chk("R10", status & 8'h08, 8'h00);
    ev_ninth_clk = 1; tick("R10");
    ev_stop_det = 1; tick("R10");
    chk("R10", status & 8'h08, 8'h08);

    // R6 / R5: tx-done gated by tx-empty, both cleared by transmit write.
    txd_wr = 1; tick("R5");
    ev_ninth_clk = 1; tick("R6");
    chk("R6", status & 8'h40, 8'h00);
    ev_tx_load = 1; tick("R5");
    ev_ninth_clk = 1; tick("R6");
    chk("R6", status & 8'hC0, 8'hC0);
    txd_wr = 1; tick("R5");
    chk("R5", status & 8'hC0, 8'h00);

    // R9: address hit ignored when master.
    is_master = 1; ev_addr_match = 1; tick("R9");
    chk("R9", status & 8'h02, 8'h00);
    is_master = 0;

    // R7 / R8: overrun and nack in synchronous mode.
    sync_mode = 1;
    ev_nack = 1; tick("R8");
    chk("R8", status & 8'h10, 8'h00);
    ev_rx_load = 1; tick("R4");
    ev_last_rx_bit = 1; tick("R7");
    chk("R7", status & 8'h04, 8'h04);
    sync_mode = 0;

    // R12: enable gating of the request.
    irq_en = 8'h00; tick("R12");
    chk("R12", {7'd0, irq}, 8'h00);
    irq_en = 8'h20; tick("R12");
    chk("R12", {7'd0, irq}, 8'h01);

    for (int i = 0; i < 4000; i++) begin
      rand_inputs();
      tick("R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule